// File: doc/BRIEF.md
# Parity-Guarded Single-Port RAM

This block wraps a synchronous single-port memory and stores one check bit next to every word. On a write, the check bit is formed from the incoming word and written in the same cycle as the word. On a read, the word that comes out of the array is folded again, and the result is compared with the check bit that was stored with it. Any disagreement is reported in the same cycle in which the read data appears, so the protection adds no cycle to the read path.

A disagreement produces three outputs. The first is a one-cycle interrupt pulse. The second is a sticky flag, which also records the address of the first failing read and holds both until software clears them. The third is a trip line, meant to be wired straight into emergency shutdown logic. A test-only port can invert any single stored data bit or check bit, so that detection can be exercised in simulation.

Top module: `pram_guard`

## Requirements
- R1: The stored check bit is even parity, the XOR of all data bits of the word. It is written in the same cycle as the word.
- R2: A read of an uncorrupted word returns the last value written to that address, and `par_err` stays low.
- R3: `rd_data`, `rd_valid` and `par_err` are valid exactly one clock after the cycle in which `rd_en` is sampled high with `wr_en` low.
- R4: When one stored data bit of a word has been inverted, a read of that word raises `par_err`.
- R5: When only the stored check bit of a word has been inverted, a read of that word raises `par_err`.
- R6: An even number of inverted bits in one word (data or check bit) is not flagged. The read returns the corrupted data.
- R7: `par_err` is high only in a cycle where `rd_valid` is high. Idle cycles never raise it.
- R8: The cycle after a `par_err` pulse, `err_sticky` is high. `err_addr` holds the address of the first failing read and is not overwritten by later failures while the flag stays set.
- R9: `clr` drops `err_sticky` on the next clock. If `par_err` is high in the same cycle as `clr`, the new failure wins: the flag stays set and `err_addr` takes the new address.
- R10: `trip` is high whenever `par_err` or `err_sticky` is high, and low otherwise.
- R11: When `wr_en` and `rd_en` are both high, only the write is performed. `rd_valid` stays low in the next cycle.
- R12: Writing a word recomputes its check bit, which removes earlier injected faults. An injection aimed at the address being written in the same cycle is dropped. `fi_sel` values 0 to DW-1 pick a data bit, and the value DW picks the check bit.
- R13: After reset, `rd_valid`, `par_err`, `err_sticky`, `trip` and `err_addr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | AW | Word address for read or write |
| wr_en | input | 1 | Write strobe; has priority over `rd_en` |
| wr_data | input | DW | Data to store |
| rd_en | input | 1 | Read strobe |
| rd_data | output | DW | Read data, one cycle after the strobe |
| rd_valid | output | 1 | Marks the cycle in which `rd_data` is valid |
| par_err | output | 1 | Parity mismatch interrupt pulse, aligned with `rd_data` |
| err_sticky | output | 1 | Latched error flag |
| err_addr | output | AW | Address of the first failing read |
| clr | input | 1 | Clears `err_sticky` |
| trip | output | 1 | Shutdown line: the current error or the latched error |
| fi_en | input | 1 | Test only: invert one stored bit |
| fi_addr | input | AW | Test only: target word |
| fi_sel | input | SW | Test only: bit index; the value DW selects the check bit |

## Verification
The bench builds the block with DW=8 and DEPTH=16, so AW=4 and SW=4. This keeps the whole array small enough to fill and read back in full. It also lets every data bit position and the check bit (`fi_sel`=8) be targeted. Because the width is small, single and paired inversions, including a data bit paired with the check bit, fall in a handful of cycles. The same-cycle collisions can also be reached directly: a write against a read, a write against an injection, and a clear against a new error.

// File: rtl/pram_pkg.sv
`timescale 1ns/1ps
package pram_pkg;
  localparam int MAX_DW = 64;

  // even parity: XOR fold of every bit
  function automatic logic fold_xor(input logic [MAX_DW-1:0] v);
    logic r;
    r = 1'b0;
    for (int i = 0; i < MAX_DW; i++) r = r ^ v[i];
    return r;
  endfunction
endpackage

// File: rtl/pram_store.sv
`timescale 1ns/1ps
module pram_store import pram_pkg::*; #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int SW    = $clog2(DW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic          fi_en,
  input  logic [AW-1:0] fi_addr,
  input  logic [SW-1:0] fi_sel,
  output logic [DW-1:0] rd_data,
  output logic          rd_par,
  output logic          rd_valid,
  output logic [AW-1:0] rd_addr
);
  logic [DW-1:0] mem [DEPTH];
  logic [DEPTH-1:0] par_bits;

  logic          wr_par;
  logic          rd_fire;
  logic          fi_fire;
  logic          fi_par_hit;
  logic [DW-1:0] fi_mask;

  assign wr_par     = fold_xor(MAX_DW'(wr_data));
  assign rd_fire    = rd_en && !wr_en;
  assign fi_fire    = fi_en && !(wr_en && (fi_addr == addr));
  assign fi_par_hit = (fi_sel == SW'(DW));
  assign fi_mask    = DW'(1) << fi_sel;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[addr]      <= wr_data;
      par_bits[addr] <= wr_par;
    end
    if (fi_fire) begin
      if (fi_par_hit) par_bits[fi_addr] <= ~par_bits[fi_addr];
      else            mem[fi_addr]      <= mem[fi_addr] ^ fi_mask;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_fire) begin
      rd_data <= mem[addr];
      rd_par  <= par_bits[addr];
      rd_addr <= addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= rd_fire;
  end

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en) |=> rd_valid); // R3
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !rd_valid); // R11
endmodule

// File: rtl/pram_check.sv
`timescale 1ns/1ps
module pram_check import pram_pkg::*; #(
  parameter int DW = 8
) (
  input  logic          rd_valid,
  input  logic [DW-1:0] rd_data,
  input  logic          rd_par,
  output logic          mismatch,
  output logic          err
);
  logic recomputed;

  assign recomputed = fold_xor(MAX_DW'(rd_data));
  assign mismatch   = recomputed ^ rd_par;
  assign err        = rd_valid && mismatch;
endmodule

// File: rtl/pram_err_log.sv
`timescale 1ns/1ps
module pram_err_log #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          err,
  input  logic [AW-1:0] rd_addr,
  input  logic          clr,
  output logic          sticky,
  output logic [AW-1:0] first_addr
);
  logic capture;

  assign capture = err && (!sticky || clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky     <= 1'b0;
      first_addr <= '0;
    end else begin
      if (capture) first_addr <= rd_addr;
      if (err)      sticky <= 1'b1;
      else if (clr) sticky <= 1'b0;
    end
  end

  AST_STICKY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> sticky); // R8
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky && !clr) |=> $stable(first_addr)); // R8
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !err) |=> !sticky); // R9
endmodule

// File: rtl/pram_guard.sv
`timescale 1ns/1ps
module pram_guard #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int SW    = $clog2(DW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          par_err,
  output logic          err_sticky,
  output logic [AW-1:0] err_addr,
  input  logic          clr,
  output logic          trip,
  input  logic          fi_en,
  input  logic [AW-1:0] fi_addr,
  input  logic [SW-1:0] fi_sel
);
  logic          stored_par;
  logic [AW-1:0] rd_addr_q;
  logic          raw_mismatch;

  pram_store #(.DW(DW), .DEPTH(DEPTH), .AW(AW), .SW(SW)) u_store (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .fi_en(fi_en), .fi_addr(fi_addr), .fi_sel(fi_sel),
    .rd_data(rd_data), .rd_par(stored_par), .rd_valid(rd_valid),
    .rd_addr(rd_addr_q)
  );

  pram_check #(.DW(DW)) u_check (
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_par(stored_par),
    .mismatch(raw_mismatch), .err(par_err)
  );

  pram_err_log #(.AW(AW)) u_log (
    .clk(clk), .rst_n(rst_n), .err(par_err), .rd_addr(rd_addr_q),
    .clr(clr), .sticky(err_sticky), .first_addr(err_addr)
  );

  assign trip = par_err || err_sticky;

  AST_ERR_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |-> rd_valid); // R7
  AST_TRIP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky |-> trip); // R10
  AST_FRESH_READ_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !fi_en) ##1 (rd_en && !wr_en && !fi_en && $stable(addr)) |=> !par_err); // R1
endmodule

// File: tb/test_pram_guard.sv
`timescale 1ns/1ps
module test_pram_guard;
  localparam int DW = 8;
  localparam int DEPTH = 16;
  localparam int AW = 4;
  localparam int SW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0, clr = 1'b0, fi_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] fi_addr = '0;
  logic [SW-1:0] fi_sel = '0;
  logic [DW-1:0] rd_data;
  logic rd_valid, par_err, err_sticky, trip;
  logic [AW-1:0] err_addr;

  always #2 clk = ~clk;

  pram_guard #(.DW(DW), .DEPTH(DEPTH)) i_pram_guard (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid), .par_err(par_err),
    .err_sticky(err_sticky), .err_addr(err_addr), .clr(clr), .trip(trip),
    .fi_en(fi_en), .fi_addr(fi_addr), .fi_sel(fi_sel)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct { logic [DW-1:0] data; logic err; int at; string req; } exp_t;
  exp_t q[$];

  // bench model of the array
  logic [DW-1:0] ref_val [DEPTH];
  logic [DW-1:0] ref_flip [DEPTH];
  logic          ref_pflip [DEPTH];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // monitor: pops expected read results
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (!rd_valid && par_err) chk("R7 idle error", 1, 0);
      if (rd_valid) begin
        if (q.size() == 0) chk("R11 unexpected rd_valid", 1, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk({e.req, " latency (R3)"}, cyc, e.at + 1);
          chk({e.req, " data"}, 32'(rd_data), 32'(e.data));
          chk({e.req, " par_err"}, 32'(par_err), 32'(e.err));
          chk("R10 trip with error", 32'(trip), 32'(par_err | err_sticky));
        end
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_write(logic [AW-1:0] a, logic [DW-1:0] d);
    addr = a; wr_data = d; wr_en = 1;
    ref_val[a] = d; ref_flip[a] = '0; ref_pflip[a] = 0;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic do_read(logic [AW-1:0] a, string req);
    exp_t e;
    int n;
    n = $countones(ref_flip[a]) + (ref_pflip[a] ? 1 : 0);
    e.data = ref_val[a] ^ ref_flip[a];
    e.err = n[0];
    e.at = cyc;
    e.req = req;
    q.push_back(e);
    addr = a; rd_en = 1;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic inject(logic [AW-1:0] a, int b);
    fi_addr = a; fi_sel = SW'(b); fi_en = 1;
    if (b == DW) ref_pflip[a] = ~ref_pflip[a];
    else ref_flip[a][b] = ~ref_flip[a][b];
    @(negedge clk);
    fi_en = 0;
  endtask

  task automatic do_clear();
    clr = 1;
    @(negedge clk);
    clr = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R13 reset state
    chk("R13 rd_valid", 32'(rd_valid), 0);
    chk("R13 par_err", 32'(par_err), 0);
    chk("R13 err_sticky", 32'(err_sticky), 0);
    chk("R13 trip", 32'(trip), 0);
    chk("R13 err_addr", 32'(err_addr), 0);
    rst_n = 1;
    idle(2);

    // R1 R2: fill and read back
    for (int i = 0; i < DEPTH; i++) do_write(AW'(i), DW'(i * 37 + 11));
    for (int i = 0; i < DEPTH; i++) do_read(AW'(i), "R2 clean read");
    idle(4);
    chk("R7 no sticky after clean reads", 32'(err_sticky), 0);

    // R4 single data bit
    inject(5, 3);
    do_read(5, "R4 data bit flip");
    idle(2);
    chk("R8 sticky set", 32'(err_sticky), 1);
    chk("R8 first address", 32'(err_addr), 5);
    chk("R10 trip from sticky", 32'(trip), 1);

    // R5 parity bit only
    inject(9, DW);
    do_read(9, "R5 check bit flip");
    idle(2);
    chk("R8 address kept", 32'(err_addr), 5);

    // R9 plain clear
    do_clear();
    chk("R9 sticky cleared", 32'(err_sticky), 0);
    chk("R10 trip low", 32'(trip), 0);

    // R6 even counts
    inject(2, 0); inject(2, 7);
    do_read(2, "R6 double data flip");
    inject(4, 1); inject(4, DW);
    do_read(4, "R6 data plus check flip");
    idle(2);
    chk("R6 no sticky", 32'(err_sticky), 0);

    // R12 rewrite heals
    do_write(5, 8'hA5);
    do_read(5, "R12 rewrite heals");
    // R12 injection dropped on collision with write
    addr = 10; wr_data = 8'h3C; wr_en = 1;
    fi_addr = 10; fi_sel = 2; fi_en = 1;
    ref_val[10] = 8'h3C; ref_flip[10] = '0; ref_pflip[10] = 0;
    @(negedge clk);
    wr_en = 0; fi_en = 0;
    do_read(10, "R12 injection dropped");

    // R11 write wins over read
    addr = 7; wr_data = 8'h5E; wr_en = 1; rd_en = 1;
    ref_val[7] = 8'h5E; ref_flip[7] = '0; ref_pflip[7] = 0;
    @(negedge clk);
    wr_en = 0; rd_en = 0;
    chk("R11 no read on write", 32'(rd_valid), 0);
    do_read(7, "R11 written value");
    idle(2);

    // R9 error in the clear cycle wins
    do_read(9, "R5 check bit again");
    idle(2);
    chk("R8 sticky for 9", 32'(err_addr), 9);
    inject(3, 0);
    do_read(3, "R4 bit0 flip");
    do_clear();
    chk("R9 new error keeps sticky", 32'(err_sticky), 1);
    chk("R9 new address taken", 32'(err_addr), 3);
    do_clear();
    chk("R9 cleared after", 32'(err_sticky), 0);
    idle(3);
    chk("R3 all reads returned", q.size(), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule